// File: doc/BRIEF.md
# Banked binary point register bank

This block holds, for each processor attached to an interrupt controller's CPU interface, the binary point value that decides where an interrupt priority is split into a group-priority part and a subpriority part. It also holds the 8-bit priority mask of each processor. A simple register bus reaches the block. Each access carries a CPU index, a byte offset, read and write strobes, write data and a secure-access attribute.

When the build enables security extensions, every processor has two binary point copies. The primary copy serves secure accesses. The alias copy holds the non-secure value. Which copy an access reaches depends on three things: the offset, the access attribute, and the build configuration (security extensions present or not, architecture revision 1 or 2). The decode includes read-as-zero and write-ignored cases. Every copy of every processor is driven out continuously to the priority-grouping logic.

Top module: `bpr_bank`

## Requirements
- R1: After reset, every primary copy is 0, every alias copy is 1, every priority mask is 0, and read data is 0.
- R2: A binary point write keeps only bits [2:0] of write data. A read of a binary point returns the value in bits [2:0], and all higher bits are zero.
- R3: Offset 0x08 reaches the primary copy in two cases: a secure access, or any access when security extensions are absent. Any 3-bit value may be stored there (minimum 0).
- R4: With security extensions present, a non-secure access to offset 0x08 reaches the alias copy and leaves the primary copy untouched. A written value below 1 is stored as 1.
- R5: With security extensions present, a secure access to offset 0x1C reaches the alias copy, and a written 0 is stored as 1.
- R6: With security extensions present, a non-secure access to offset 0x1C reads as zero, and its write changes nothing.
- R7: A revision 2 build without security extensions has a real register at offset 0x1C: the alias copy, clamped to at least 1, reachable with either attribute. A revision 1 build without security extensions reads 0x1C as zero and ignores writes to it.
- R8: Each processor's registers are separate and are selected by the CPU index. An index at or above the number of processors reads as zero and its writes change nothing.
- R9: Offset 0x04 holds an 8-bit priority mask for each processor, written from write data bits [7:0]. The access attribute does not affect it.
- R10: Read data appears in the cycle after the read strobe. A read and a write to the same register in one cycle returns the old value. Read data is zero after an unmapped offset and in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_cpu | input | CPU_W | Processor index of the access |
| bus_off | input | 8 | Byte offset of the register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_secure | input | 1 | Access is secure |
| bus_rdata | output | DATA_W | Registered read data |
| pmask_o | output | NCPU*8 | Priority mask for each processor |
| bp_main_o | output | NCPU*3 | Primary (secure or unbanked) binary point for each processor |
| bp_alias_o | output | NCPU*3 | Alias (non-secure or group 1) binary point for each processor |

## Verification
Three builds share one stimulus stream: security extensions on at revision 2, off at revision 2, and off at revision 1. The same offset and attribute therefore land on the primary copy, the alias copy, or nothing, depending on the build. Directed cases write 0 so that the two clamp floors differ. They also write wide data to expose the bit truncation, use an out-of-range CPU index, and issue a read together with a write to show old-value return. Random accesses then mix the mapped and unmapped offsets and both attributes across all processor indices. Comparing every processor's outputs after each access exposes a write that lands in the wrong copy or the wrong processor.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
    localparam int BP_W  = 3;
    localparam int PM_W  = 8;
    localparam int OFF_W = 8;

    localparam logic [OFF_W-1:0] OFF_PMASK = 8'h04;
    localparam logic [OFF_W-1:0] OFF_BP    = 8'h08;
    localparam logic [OFF_W-1:0] OFF_ABP   = 8'h1C;

    localparam logic [BP_W-1:0] FLOOR_MAIN  = 3'd0;
    localparam logic [BP_W-1:0] FLOOR_ALIAS = 3'd1;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_PMASK = 2'd1,
        TGT_MAIN  = 2'd2,
        TGT_ALIAS = 2'd3
    } tgt_e;

    typedef struct packed {
        logic [PM_W-1:0] pm;
        logic [BP_W-1:0] mn;
        logic [BP_W-1:0] al;
    } cpu_regs_t;

    function automatic logic [BP_W-1:0] floor_at(input logic [BP_W-1:0] v,
                                                 input logic [BP_W-1:0] lo);
        return (v < lo) ? lo : v;
    endfunction
endpackage

// File: rtl/bpr_decode.sv
module bpr_decode
    import bpr_pkg::*;
#(
    parameter int NCPU    = 3,
    parameter bit SEC_EXT = 1'b1,
    parameter int REV     = 2,
    parameter int CPU_W   = 2
) (
    input  logic [CPU_W-1:0] cpu,
    input  logic [OFF_W-1:0] off,
    input  logic             secure,
    output tgt_e             tgt
);
    localparam bit HAS_GROUPS = (REV >= 2) || SEC_EXT;

    logic ns_banked;
    logic cpu_ok;

    always_comb begin
        ns_banked = SEC_EXT && !secure;
        cpu_ok    = (int'(cpu) < NCPU);
        tgt       = TGT_NONE;
        if (cpu_ok) begin
            case (off)
                OFF_PMASK: tgt = TGT_PMASK;
                OFF_BP:    tgt = ns_banked ? TGT_ALIAS : TGT_MAIN;
                OFF_ABP:   tgt = (!HAS_GROUPS || ns_banked) ? TGT_NONE : TGT_ALIAS;
                default:   tgt = TGT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/bpr_cpu_regs.sv
module bpr_cpu_regs
    import bpr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_pm,
    input  logic            wr_mn,
    input  logic            wr_al,
    input  logic [PM_W-1:0] wdata,
    output logic [PM_W-1:0] pm_o,
    output logic [BP_W-1:0] mn_o,
    output logic [BP_W-1:0] al_o
);
    cpu_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_pm) regs_d.pm = wdata;
        if (wr_mn) regs_d.mn = floor_at(wdata[BP_W-1:0], FLOOR_MAIN);
        if (wr_al) regs_d.al = floor_at(wdata[BP_W-1:0], FLOOR_ALIAS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.pm <= '0;
            regs_q.mn <= FLOOR_MAIN;
            regs_q.al <= FLOOR_ALIAS;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pm_o = regs_q.pm;
    assign mn_o = regs_q.mn;
    assign al_o = regs_q.al;
endmodule

// File: rtl/bpr_rdport.sv
module bpr_rdport
    import bpr_pkg::*;
#(
    parameter int NCPU   = 3,
    parameter int CPU_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd,
    input  logic [CPU_W-1:0]     cpu,
    input  tgt_e                 tgt,
    input  logic [NCPU*PM_W-1:0] pm_i,
    input  logic [NCPU*BP_W-1:0] mn_i,
    input  logic [NCPU*BP_W-1:0] al_i,
    output logic [DATA_W-1:0]    rdata
);
    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (int'(cpu) == c) begin
                case (tgt)
                    TGT_PMASK: sel = DATA_W'(pm_i[c*PM_W +: PM_W]);
                    TGT_MAIN:  sel = DATA_W'(mn_i[c*BP_W +: BP_W]);
                    TGT_ALIAS: sel = DATA_W'(al_i[c*BP_W +: BP_W]);
                    default:   sel = '0;
                endcase
            end
        end
        rdata_d = rd ? sel : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/bpr_bank.sv
module bpr_bank
    import bpr_pkg::*;
#(
    parameter int NCPU    = 3,
    parameter bit SEC_EXT = 1'b1,
    parameter int REV     = 2,
    parameter int DATA_W  = 32,
    localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU + 1) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CPU_W-1:0]     bus_cpu,
    input  logic [OFF_W-1:0]     bus_off,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_secure,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NCPU*PM_W-1:0] pmask_o,
    output logic [NCPU*BP_W-1:0] bp_main_o,
    output logic [NCPU*BP_W-1:0] bp_alias_o
);
    tgt_e tgt;

    bpr_decode #(
        .NCPU(NCPU), .SEC_EXT(SEC_EXT), .REV(REV), .CPU_W(CPU_W)
    ) u_decode (
        .cpu(bus_cpu), .off(bus_off), .secure(bus_secure), .tgt(tgt)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic hit;
        assign hit = bus_wr && (int'(bus_cpu) == c);

        bpr_cpu_regs u_regs (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_pm (hit && (tgt == TGT_PMASK)),
            .wr_mn (hit && (tgt == TGT_MAIN)),
            .wr_al (hit && (tgt == TGT_ALIAS)),
            .wdata (bus_wdata[PM_W-1:0]),
            .pm_o  (pmask_o[c*PM_W +: PM_W]),
            .mn_o  (bp_main_o[c*BP_W +: BP_W]),
            .al_o  (bp_alias_o[c*BP_W +: BP_W])
        );
    end

    bpr_rdport #(
        .NCPU(NCPU), .CPU_W(CPU_W), .DATA_W(DATA_W)
    ) u_rdport (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .cpu   (bus_cpu),
        .tgt   (tgt),
        .pm_i  (pmask_o),
        .mn_i  (bp_main_o),
        .al_i  (bp_alias_o),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/bpr_bank_chk.sv
module bpr_bank_chk
    import bpr_pkg::*;
#(
    parameter int NCPU    = 3,
    parameter bit SEC_EXT = 1'b1,
    parameter int REV     = 2,
    parameter int DATA_W  = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [OFF_W-1:0]     bus_off,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic                 bus_secure,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [NCPU*PM_W-1:0] pmask_o,
    input logic [NCPU*BP_W-1:0] bp_main_o,
    input logic [NCPU*BP_W-1:0] bp_alias_o
);
    localparam bit HAS_GROUPS = (REV >= 2) || SEC_EXT;

    for (genvar c = 0; c < NCPU; c++) begin : g_floor
        p_alias_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
            bp_alias_o[c*BP_W +: BP_W] != 3'd0);
    end

    p_ns_bp_keeps_main_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (SEC_EXT && bus_wr && !bus_secure && bus_off == OFF_BP) |=> $stable(bp_main_o));

    p_ns_abp_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (SEC_EXT && bus_wr && !bus_secure && bus_off == OFF_ABP) |=> $stable(bp_alias_o));

    p_nogroup_abp_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_GROUPS && bus_rd && bus_off == OFF_ABP) |=> (bus_rdata == '0));

    p_pmask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_off == OFF_PMASK) |=> $stable(pmask_o));

    p_idle_rdata_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    p_bp_read_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_off == OFF_BP || bus_off == OFF_ABP)) |=> (bus_rdata[DATA_W-1:BP_W] == '0));
endmodule

bind bpr_bank bpr_bank_chk #(
    .NCPU(NCPU), .SEC_EXT(SEC_EXT), .REV(REV), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_off(bus_off), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_secure(bus_secure), .bus_rdata(bus_rdata),
    .pmask_o(pmask_o), .bp_main_o(bp_main_o), .bp_alias_o(bp_alias_o)
);

// File: tb/bpr_bank_test.sv
`timescale 1ns/1ps
module bpr_bank_test;
    localparam int NCPU = 3;
    localparam int CPUW = 2;
    localparam int DW   = 32;
    localparam int NCFG = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CPUW-1:0] bus_cpu = '0;
    logic [7:0]    bus_off = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_secure = 1'b0;

    logic [DW-1:0]     rdata [NCFG];
    logic [NCPU*8-1:0] pm_o  [NCFG];
    logic [NCPU*3-1:0] mn_o  [NCFG];
    logic [NCPU*3-1:0] al_o  [NCFG];

    int tests = 0;
    int fails = 0;

    int m_pm [NCFG][NCPU];
    int m_mn [NCFG][NCPU];
    int m_al [NCFG][NCPU];

    always #2.5 clk = ~clk;

    // cfg 0: security on, rev 2; cfg 1: security off, rev 2; cfg 2: security off, rev 1
    bpr_bank #(.NCPU(NCPU), .SEC_EXT(1'b1), .REV(2), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_off(bus_off),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .bus_rdata(rdata[0]), .pmask_o(pm_o[0]), .bp_main_o(mn_o[0]), .bp_alias_o(al_o[0]));

    bpr_bank #(.NCPU(NCPU), .SEC_EXT(1'b0), .REV(2), .DATA_W(DW)) uut_nosec (
        .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_off(bus_off),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .bus_rdata(rdata[1]), .pmask_o(pm_o[1]), .bp_main_o(mn_o[1]), .bp_alias_o(al_o[1]));

    bpr_bank #(.NCPU(NCPU), .SEC_EXT(1'b0), .REV(1), .DATA_W(DW)) uut_v1 (
        .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_off(bus_off),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .bus_rdata(rdata[2]), .pmask_o(pm_o[2]), .bp_main_o(mn_o[2]), .bp_alias_o(al_o[2]));

    function automatic bit cfg_sec(input int cfg);
        return cfg == 0;
    endfunction

    function automatic bit cfg_groups(input int cfg);
        return cfg != 2;
    endfunction

    // 0 none, 1 pmask, 2 primary, 3 alias
    function automatic int target(input int cfg, input int cpu, input int off, input bit sec);
        bit nsb;
        nsb = cfg_sec(cfg) && !sec;
        if (cpu >= NCPU) return 0;
        if (off == 'h04) return 1;
        if (off == 'h08) return nsb ? 3 : 2;
        if (off == 'h1C) return (!cfg_groups(cfg) || nsb) ? 0 : 3;
        return 0;
    endfunction

    function automatic int model_read(input int cfg, input int cpu, input int off, input bit sec);
        case (target(cfg, cpu, off, sec))
            1: return m_pm[cfg][cpu];
            2: return m_mn[cfg][cpu];
            3: return m_al[cfg][cpu];
            default: return 0;
        endcase
    endfunction

    task automatic model_write(input int cfg, input int cpu, input int off, input bit sec,
                               input logic [DW-1:0] d);
        int v;
        v = int'(d[2:0]);
        case (target(cfg, cpu, off, sec))
            1: m_pm[cfg][cpu] = int'(d[7:0]);
            2: m_mn[cfg][cpu] = v;
            3: m_al[cfg][cpu] = (v < 1) ? 1 : v;
            default: ;
        endcase
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        for (int g = 0; g < NCFG; g++) begin
            for (int c = 0; c < NCPU; c++) begin
                check(req, $sformatf("cfg%0d cpu%0d pmask", g, c), int'(pm_o[g][c*8 +: 8]), m_pm[g][c]);
                check(req, $sformatf("cfg%0d cpu%0d primary", g, c), int'(mn_o[g][c*3 +: 3]), m_mn[g][c]);
                check(req, $sformatf("cfg%0d cpu%0d alias", g, c), int'(al_o[g][c*3 +: 3]), m_al[g][c]);
            end
        end
    endtask

    task automatic access(input string req, input bit rd, input bit wr, input int cpu,
                          input int off, input bit sec, input logic [DW-1:0] d);
        int exp_rd [NCFG];
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_cpu = CPUW'(cpu); bus_off = 8'(off);
        bus_secure = sec; bus_wdata = d;
        for (int g = 0; g < NCFG; g++)
            exp_rd[g] = rd ? model_read(g, cpu, off, sec) : 0;
        @(posedge clk);
        if (wr) for (int g = 0; g < NCFG; g++) model_write(g, cpu, off, sec, d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        for (int g = 0; g < NCFG; g++)
            check(req, $sformatf("cfg%0d rdata", g), int'(rdata[g]), exp_rd[g]);
        check_outputs(req);
    endtask

    function automatic string tag_of(input int off, input bit sec, input int cpu);
        if (cpu >= NCPU) return "R8";
        if (off == 'h04) return "R9";
        if (off == 'h08) return sec ? "R3" : "R4";
        if (off == 'h1C) return sec ? "R5" : "R6";
        return "R10";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int offs [5] = '{'h04, 'h08, 'h1C, 'h0C, 'h10};
        void'($urandom(32'd20240611));
        for (int g = 0; g < NCFG; g++)
            for (int c = 0; c < NCPU; c++) begin
                m_pm[g][c] = 0; m_mn[g][c] = 0; m_al[g][c] = 1;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        for (int g = 0; g < NCFG; g++) check("R1", "reset rdata", int'(rdata[g]), 0);
        check_outputs("R1");
        rst_n = 1'b1;

        // R2/R3 wide write to primary, read back truncated
        access("R2", 1'b0, 1'b1, 0, 'h08, 1'b1, 32'hFFFF_FFF5);
        access("R2", 1'b1, 1'b0, 0, 'h08, 1'b1, '0);
        access("R3", 1'b0, 1'b1, 0, 'h08, 1'b1, 32'h0);
        access("R3", 1'b1, 1'b0, 0, 'h08, 1'b0, '0);
        // R4 non-secure 0x08 write of 0: alias floor 1 on cfg0, primary 0 elsewhere
        access("R4", 1'b0, 1'b1, 1, 'h08, 1'b1, 32'h3);
        access("R4", 1'b0, 1'b1, 1, 'h08, 1'b0, 32'h0);
        access("R4", 1'b1, 1'b0, 1, 'h08, 1'b0, '0);
        access("R4", 1'b0, 1'b1, 1, 'h08, 1'b0, 32'h6);
        // R5 secure 0x1C alias, with floor
        access("R5", 1'b0, 1'b1, 2, 'h1C, 1'b1, 32'h6);
        access("R5", 1'b1, 1'b0, 2, 'h1C, 1'b1, '0);
        access("R5", 1'b0, 1'b1, 2, 'h1C, 1'b1, 32'h8);
        // R6 / R7 non-secure 0x1C
        access("R6", 1'b0, 1'b1, 2, 'h1C, 1'b0, 32'h7);
        access("R7", 1'b1, 1'b0, 2, 'h1C, 1'b0, '0);
        access("R7", 1'b0, 1'b1, 0, 'h1C, 1'b1, 32'h0);
        // R8 out-of-range processor index
        access("R8", 1'b0, 1'b1, 3, 'h08, 1'b1, 32'h7);
        access("R8", 1'b0, 1'b1, 3, 'h04, 1'b1, 32'hFF);
        access("R8", 1'b1, 1'b0, 3, 'h04, 1'b1, '0);
        // R9 priority mask, attribute-independent
        access("R9", 1'b0, 1'b1, 0, 'h04, 1'b0, 32'h1A5);
        access("R9", 1'b1, 1'b0, 0, 'h04, 1'b1, '0);
        // R10 old value on simultaneous read/write, unmapped offset, idle
        access("R10", 1'b1, 1'b1, 0, 'h04, 1'b1, 32'h3C);
        access("R10", 1'b1, 1'b1, 1, 'h1C, 1'b1, 32'h2);
        access("R10", 1'b1, 1'b1, 0, 'h0C, 1'b1, 32'h5);
        access("R10", 1'b0, 1'b0, 0, 'h04, 1'b1, '0);

        for (int i = 0; i < 400; i++) begin
            int cpu, off;
            bit sec, rd, wr;
            cpu = int'($urandom % 4);
            off = offs[$urandom % 5];
            sec = 1'($urandom % 2);
            rd  = 1'($urandom % 2);
            wr  = 1'($urandom % 2);
            access(tag_of(off, sec, cpu), rd, wr, cpu, off, sec, DW'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule